// File: doc/BRIEF.md
# BCD Calendar Counter with Selectable Leap Rule

This block holds the date part of a real-time clock in packed BCD. It has day-of-week, day-of-month, month and year, and it can also have a century register. A one-cycle pulse from the time-of-day logic marks each midnight. On that pulse the day-of-week and the day-of-month both advance. A day-of-month wrap carries into the month, a month wrap carries into the year, and a year wrap carries into the century.

The last day of each month comes from the month and from the leap-year status. A parameter picks how leap years are found. One rule looks at the year register alone. The other is the full Gregorian rule, which also uses the century register. When the block is built without a century register, a year wrap toggles a flag bit stored in the month register.

Software loads each register through a write port. Only the implemented bits of each register are stored. If an illegal value is loaded, it keeps counting in a defined BCD way until it meets the wrap value.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the registers read: day-of-week 01h, date 01h, month 01h (flag bit clear), year 00h, century 00h.
- R2: The register addresses are 0 for day-of-week, 1 for date, 2 for month, 3 for year and 4 for century. Address 5 and above read 00h. A write stores only the implemented bits: day-of-week bits 2:0, date bits 5:0, month bits 7 and 4:0, and all 8 bits of year and century. Unimplemented bits read 0. For example, 1Fh reads back 07h in day-of-week, and 2Ah reads back 0Ah in month.
- R3: On each day pulse, day-of-week steps 1 to 7 and then returns to 1. A loaded 0 steps to 1, so that first week has eight days.
- R4: On a day pulse, the date steps up to the month's last date and then returns to 01h, advancing the month. Months 04h, 06h, 09h and 11h end at 30h. Months 01h, 03h, 05h, 07h, 08h, 10h and 12h end at 31h.
- R5: February (02h) ends at 29h in a leap year and at 28h otherwise.
- R6: Month 12h returns to 01h and advances the year. Year 99h returns to 00h.
- R7: Without a century register, a year wrap toggles month bit 7, and address 4 reads 00h even after a write to it.
- R8: With a century register, a year wrap advances the century. Century 99h returns to 00h. Month bit 7 is left unchanged.
- R9: With the year-only rule, a year is leap when the BCD year value is divisible by 4, and year 00h is always leap. With the Gregorian rule, year 00h is leap only when the century value is divisible by 4.
- R10: An illegal value counts like this. If the low digit is 9 or more, it becomes 0 and the high digit adds one. Otherwise the low digit adds one. The register wraps only when it exactly equals its last value. For example, date 2Dh in month 01h steps 30h, 31h, 01h. Month 0Ah ends at 31 days and then steps to 10h.
- R11: Without a day pulse or a write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| day_tick | input | 1 | One-cycle midnight pulse from the time-of-day logic |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data, packed BCD |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | DATA_W | Read data for the register at rd_addr (combinational) |

## Verification
The hardest case to reach is the three-way split on February of year 00h. It depends on which leap rule is built in and whether a century register exists, so a single instance can never show all of it. The bench builds three variants and drives them with the same writes and pulses: Gregorian with a century register, year-only with a century register, and no century register. It loads each register just below its wrap point, so that one pulse shows the leap decision, the year carry and the flag-bit toggle side by side. Illegal loads are placed just short of a month end, so that the BCD stepping and the wrap are seen within a few pulses.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int CAL_A_DOW  = 0;
   localparam int CAL_A_DATE = 1;
   localparam int CAL_A_MON  = 2;
   localparam int CAL_A_YEAR = 3;
   localparam int CAL_A_CENT = 4;

   // divisibility by 4 of a two-digit BCD value: 10*t + o == 2*t + o (mod 4)
   function automatic logic bcd_div4(input logic [7:0] v);
      logic [4:0] s;
      s = {3'b000, v[4], 1'b0} + {1'b0, v[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   // last date of a BCD month (5-bit month field)
   function automatic logic [5:0] bcd_month_last(input logic [4:0] mon, input logic leap);
      logic [5:0] r;
      case (mon)
         5'h02:                      r = leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
         default:                    r = 6'h31;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
   parameter int W       = 8,
   parameter int MIN_VAL = 0,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] limit,
   output logic [W-1:0] value,
   output logic         wrap
);
   localparam int HI_W = W - 4;

   generate
      if (W < 5 || W > 8) begin : g_bad_w
         $error("cal_bcd_field: W must be 5..8");
      end
   endgenerate

   logic [3:0]      lo;
   logic [HI_W-1:0] hi;
   logic [W-1:0]    inc;

   always_comb begin
      lo = value[3:0];
      hi = value[W-1:4];
      if (lo >= 4'd9) inc = {hi + HI_W'(1), 4'h0};
      else            inc = {hi, lo + 4'd1};
   end

   assign wrap = step && (value == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= W'(RST_VAL);
      else if (wr)   value <= wdata;
      else if (step) value <= wrap ? W'(MIN_VAL) : inc;
   end

   // R10: exact match with the limit returns the field to its minimum
   p_wrap_to_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && value == limit) |=> (value == W'(MIN_VAL)));
   // R11: idle cycles leave the field untouched
   p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !wr) |=> $stable(value));
   // R2: a write lands the masked data
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (value == $past(wdata)));
endmodule

// File: rtl/cal_dow.sv
module cal_dow #(
   parameter int DOW_W = 3,
   parameter int FIRST = 1,
   parameter int LAST  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wr,
   input  logic [DOW_W-1:0] wdata,
   output logic [DOW_W-1:0] value
);
   generate
      if (LAST >= (1 << DOW_W) || FIRST > LAST) begin : g_bad_range
         $error("cal_dow: range does not fit DOW_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= DOW_W'(FIRST);
      else if (wr)   value <= wdata;
      else if (step) value <= (value == DOW_W'(LAST)) ? DOW_W'(FIRST) : value + DOW_W'(1);
   end

   // R3: after the last weekday the count returns to the first
   p_dow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && value == DOW_W'(LAST)) |=> (value == DOW_W'(FIRST)));
   // R3: a step from a value below the last adds exactly one
   p_dow_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && value < DOW_W'(LAST)) |=> (value == $past(value) + DOW_W'(1)));
endmodule

// File: rtl/cal_month_end.sv
module cal_month_end #(
   parameter bit LEAP_GREGORIAN = 1'b1
) (
   input  logic [4:0] mon,
   input  logic [7:0] year,
   input  logic [7:0] century,
   output logic       leap,
   output logic [5:0] last_date
);
   import cal_pkg::*;

   logic leap_year_only;
   logic leap_greg;

   assign leap_year_only = bcd_div4(year);
   assign leap_greg      = (year == 8'h00) ? bcd_div4(century) : bcd_div4(year);

   generate
      if (LEAP_GREGORIAN) begin : g_greg
         assign leap = leap_greg;
      end else begin : g_simple
         assign leap = leap_year_only;
      end
   endgenerate

   assign last_date = bcd_month_last(mon, leap);

   // R5: only February depends on the leap decision
   always_comb begin
      if (mon != 5'h02) a_leap_only_feb_r5: assert (last_date != 6'h29 && last_date != 6'h28);
   end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 3,
   parameter bit HAS_CENTURY    = 1'b1,
   parameter bit LEAP_GREGORIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              day_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import cal_pkg::*;

   localparam int DOW_W  = 3;
   localparam int DATE_W = 6;
   localparam int MON_W  = 5;
   localparam int YR_W   = DATA_W;

   generate
      if (DATA_W != 8)                     begin : g_bad_data  $error("bcd_calendar: DATA_W must be 8"); end
      if (ADDR_W < 3)                      begin : g_bad_addr  $error("bcd_calendar: ADDR_W must be >= 3"); end
      if (LEAP_GREGORIAN && !HAS_CENTURY)  begin : g_bad_leap  $error("bcd_calendar: Gregorian rule needs a century register"); end
   endgenerate

   logic wr_dow, wr_date, wr_mon, wr_year;
   assign wr_dow  = wr_en && (wr_addr == ADDR_W'(CAL_A_DOW));
   assign wr_date = wr_en && (wr_addr == ADDR_W'(CAL_A_DATE));
   assign wr_mon  = wr_en && (wr_addr == ADDR_W'(CAL_A_MON));
   assign wr_year = wr_en && (wr_addr == ADDR_W'(CAL_A_YEAR));

   logic [DOW_W-1:0]  dow;
   logic [DATE_W-1:0] date;
   logic [MON_W-1:0]  mon;
   logic [YR_W-1:0]   year;
   logic [YR_W-1:0]   century;
   logic [DATE_W-1:0] last_date;
   logic              leap;
   logic              date_wrap, mon_wrap, year_wrap;
   logic              cbit;

   cal_dow #(.DOW_W(DOW_W), .FIRST(1), .LAST(7)) u_dow (
      .clk(clk), .rst_n(rst_n), .step(day_tick), .wr(wr_dow),
      .wdata(wr_data[DOW_W-1:0]), .value(dow));

   cal_month_end #(.LEAP_GREGORIAN(LEAP_GREGORIAN)) u_mend (
      .mon(mon), .year(year), .century(century), .leap(leap), .last_date(last_date));

   cal_bcd_field #(.W(DATE_W), .MIN_VAL(1), .RST_VAL(1)) u_date (
      .clk(clk), .rst_n(rst_n), .step(day_tick), .wr(wr_date),
      .wdata(wr_data[DATE_W-1:0]), .limit(last_date), .value(date), .wrap(date_wrap));

   cal_bcd_field #(.W(MON_W), .MIN_VAL(1), .RST_VAL(1)) u_mon (
      .clk(clk), .rst_n(rst_n), .step(date_wrap), .wr(wr_mon),
      .wdata(wr_data[MON_W-1:0]), .limit(5'h12), .value(mon), .wrap(mon_wrap));

   cal_bcd_field #(.W(YR_W), .MIN_VAL(0), .RST_VAL(0)) u_year (
      .clk(clk), .rst_n(rst_n), .step(mon_wrap), .wr(wr_year),
      .wdata(wr_data), .limit(8'h99), .value(year), .wrap(year_wrap));

   generate
      if (HAS_CENTURY) begin : g_cent
         logic wr_cent;
         logic cent_wrap;
         assign wr_cent = wr_en && (wr_addr == ADDR_W'(CAL_A_CENT));
         cal_bcd_field #(.W(YR_W), .MIN_VAL(0), .RST_VAL(0)) u_cent (
            .clk(clk), .rst_n(rst_n), .step(year_wrap), .wr(wr_cent),
            .wdata(wr_data), .limit(8'h99), .value(century), .wrap(cent_wrap));

         // R8: the flag bit is left alone when a century register exists
         p_cbit_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (year_wrap && !wr_mon) |=> $stable(cbit));
      end else begin : g_nocent
         assign century = '0;

         // R7: a year wrap flips the flag bit
         p_cbit_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (year_wrap && !wr_mon) |=> (cbit != $past(cbit)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                       cbit <= 1'b0;
      else if (wr_mon)                  cbit <= wr_data[DATA_W-1];
      else if (!HAS_CENTURY && year_wrap) cbit <= ~cbit;
   end

   always_comb begin
      case (rd_addr)
         ADDR_W'(CAL_A_DOW):  rd_data = {{(DATA_W-DOW_W){1'b0}}, dow};
         ADDR_W'(CAL_A_DATE): rd_data = {{(DATA_W-DATE_W){1'b0}}, date};
         ADDR_W'(CAL_A_MON):  rd_data = {cbit, {(DATA_W-MON_W-1){1'b0}}, mon};
         ADDR_W'(CAL_A_YEAR): rd_data = year;
         ADDR_W'(CAL_A_CENT): rd_data = century;
         default:             rd_data = '0;
      endcase
   end

   // R4: a date wrap always lands on 01h
   p_date_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (date_wrap && !wr_date) |=> (date == 6'h01));
   // R6: December wraps to January together with a year step
   p_mon_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_wrap && !wr_mon) |=> (mon == 5'h01));
endmodule

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/100ps
module bcd_calendar_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       day_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_g, rd_s, rd_n;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // Gregorian with century register
   bcd_calendar #(.HAS_CENTURY(1'b1), .LEAP_GREGORIAN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_g));
   // year-only rule with century register
   bcd_calendar #(.HAS_CENTURY(1'b1), .LEAP_GREGORIAN(1'b0)) u_dut_simple (
      .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_s));
   // no century register
   bcd_calendar #(.HAS_CENTURY(1'b0), .LEAP_GREGORIAN(1'b0)) u_dut_nocent (
      .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_n));

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); day_tick = 1'b1;
         @(negedge clk); day_tick = 1'b0;
      end
   endtask

   task automatic set_day(input logic [7:0] c, y, m, d);
      wr(3'd4, c); wr(3'd3, y); wr(3'd2, m); wr(3'd1, d);
   endtask

   task automatic chk(input string tag, input logic [2:0] a,
                      input logic [7:0] eg, es, en);
      rd_addr = a; #1;
      checks++;
      if (rd_g !== eg || rd_s !== es || rd_n !== en) begin
         errors++;
         $display("FAIL %s addr %0d: got %h/%h/%h expected %h/%h/%h",
                  tag, a, rd_g, rd_s, rd_n, eg, es, en);
      end
   endtask

   task automatic t_reset();
      chk("R1 dow", 3'd0, 8'h01, 8'h01, 8'h01);
      chk("R1 date", 3'd1, 8'h01, 8'h01, 8'h01);
      chk("R1 month", 3'd2, 8'h01, 8'h01, 8'h01);
      chk("R1 year", 3'd3, 8'h00, 8'h00, 8'h00);
      chk("R1 century", 3'd4, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_masks();
      wr(3'd0, 8'h1F); chk("R2 dow 1F", 3'd0, 8'h07, 8'h07, 8'h07);
      wr(3'd0, 8'hF5); chk("R2 dow F5", 3'd0, 8'h05, 8'h05, 8'h05);
      wr(3'd2, 8'h2A); chk("R2 month 2A", 3'd2, 8'h0A, 8'h0A, 8'h0A);
      wr(3'd1, 8'hFF); chk("R2 date FF", 3'd1, 8'h3F, 8'h3F, 8'h3F);
      wr(3'd3, 8'hFF); chk("R2 year FF", 3'd3, 8'hFF, 8'hFF, 8'hFF);
      wr(3'd4, 8'h5A); chk("R7 century absent", 3'd4, 8'h5A, 8'h5A, 8'h00);
      chk("R2 unused addr", 3'd5, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_dow();
      set_day(8'h20, 8'h25, 8'h01, 8'h01);
      wr(3'd0, 8'h00);
      ticks(1); chk("R3 dow 0->1", 3'd0, 8'h01, 8'h01, 8'h01);
      ticks(6); chk("R3 dow 7", 3'd0, 8'h07, 8'h07, 8'h07);
      ticks(1); chk("R3 dow wrap", 3'd0, 8'h01, 8'h01, 8'h01);
   endtask

   task automatic t_month_len();
      set_day(8'h20, 8'h25, 8'h04, 8'h29);
      ticks(1); chk("R4 april 30", 3'd1, 8'h30, 8'h30, 8'h30);
      ticks(1); chk("R4 april wrap", 3'd1, 8'h01, 8'h01, 8'h01);
      chk("R4 month 05", 3'd2, 8'h05, 8'h05, 8'h05);
      set_day(8'h20, 8'h25, 8'h01, 8'h30);
      ticks(1); chk("R4 jan 31", 3'd1, 8'h31, 8'h31, 8'h31);
      ticks(1); chk("R4 jan wrap month", 3'd2, 8'h02, 8'h02, 8'h02);
   endtask

   task automatic t_leap();
      set_day(8'h20, 8'h24, 8'h02, 8'h28);
      ticks(1); chk("R5 feb leap 24", 3'd1, 8'h29, 8'h29, 8'h29);
      set_day(8'h20, 8'h23, 8'h02, 8'h28);
      ticks(1); chk("R5 feb 23 date", 3'd1, 8'h01, 8'h01, 8'h01);
      chk("R5 feb 23 month", 3'd2, 8'h03, 8'h03, 8'h03);
      set_day(8'h21, 8'h00, 8'h02, 8'h28);
      ticks(1); chk("R9 year 00 century 21", 3'd1, 8'h01, 8'h29, 8'h29);
      set_day(8'h20, 8'h00, 8'h02, 8'h28);
      ticks(1); chk("R9 year 00 century 20", 3'd1, 8'h29, 8'h29, 8'h29);
   endtask

   task automatic t_rollover();
      wr(3'd2, 8'h00); // clear flag bit
      set_day(8'h20, 8'h99, 8'h12, 8'h31);
      ticks(1);
      chk("R6 year wrap", 3'd3, 8'h00, 8'h00, 8'h00);
      chk("R7 flag set", 3'd2, 8'h01, 8'h01, 8'h81);
      chk("R8 century step", 3'd4, 8'h21, 8'h21, 8'h00);
      chk("R6 date", 3'd1, 8'h01, 8'h01, 8'h01);
      set_day(8'h99, 8'h99, 8'h92, 8'h31);
      ticks(1);
      chk("R7 flag toggles back", 3'd2, 8'h81, 8'h81, 8'h01);
      chk("R8 century wrap", 3'd4, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_illegal();
      set_day(8'h20, 8'h25, 8'h01, 8'h2D);
      ticks(1); chk("R10 2D->30", 3'd1, 8'h30, 8'h30, 8'h30);
      ticks(1); chk("R10 ->31", 3'd1, 8'h31, 8'h31, 8'h31);
      ticks(1); chk("R10 ->01", 3'd1, 8'h01, 8'h01, 8'h01);
      set_day(8'h20, 8'h25, 8'h0A, 8'h31);
      ticks(1); chk("R10 month 0A->10", 3'd2, 8'h10, 8'h10, 8'h10);
   endtask

   task automatic t_idle();
      set_day(8'h20, 8'h25, 8'h06, 8'h17);
      wr(3'd0, 8'h03);
      repeat (6) @(negedge clk);
      chk("R11 date held", 3'd1, 8'h17, 8'h17, 8'h17);
      chk("R11 dow held", 3'd0, 8'h03, 8'h03, 8'h03);
      chk("R11 month held", 3'd2, 8'h06, 8'h06, 8'h06);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masks();
      t_dow();
      t_month_len();
      t_leap();
      t_rollover();
      t_illegal();
      t_idle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule